// File: doc/BRIEF.md
# Saturating Line Error Counter Bank

This block keeps three error tallies for a framed 2.048 Mb/s line receiver. Upstream detection logic gives it one-cycle strobes for three kinds of fault: a bipolar code violation, a failed CRC-4 code word, and a corrupted frame alignment word. The block decides whether each strobe should count, using three control bits and a resync-in-progress flag. It then advances the matching 8-bit counter. Line decoding, framing and the CRC computation happen outside the block.

A counter never wraps. Once it reaches 0xFF, every further counted error raises an interrupt pulse and sets a sticky status bit. This continues until software rewrites the counter. Software can preset a counter to any value, so the distance from the preset to 0xFF sets an alarm threshold.

All access goes through a small register port. Writes are synchronous and reads are combinational.

Top module: `line_err_counters`

## Requirements
- R1: Address 0 holds the bipolar violation count, address 1 the CRC-4 error count and address 2 the frame alignment error count. Each counter rises by exactly one for each qualified strobe, and the new value reads back on `reg_rdata` in the cycle after the strobe edge.
- R2: A counter that holds 0xFF stays at 0xFF when further qualified strobes arrive. It never wraps to zero.
- R3: A qualified strobe that reaches a counter already at 0xFF drives `irq_pulse` high for exactly the one cycle after that edge, but only if the interrupt enable (bit 2 of the control register at address 4) is 1. Several such strobes in one cycle give a single pulse.
- R4: The status register at address 5 has one bit per counter, at bit positions 0, 1 and 2 for addresses 0, 1 and 2. A bit is set by a strobe that reaches its saturated counter, whatever the interrupt enable says. Writing 1 to a bit clears it, and a set in the same cycle wins over the clear.
- R5: A write to a counter address loads that value. Counting then continues upward from it, and any loaded value other than 0xFF ends the saturated behaviour.
- R6: The CRC-4 error counter counts only while the CRC enable (control bit 0) is 1.
- R7: The bipolar violation counter counts whether or not `resync_active` is high. It ignores a strobe flagged `bpv_in_subst` while the substitution-exclusion bit (control bit 1) is 1.
- R8: While `resync_active` is high, neither the CRC-4 counter nor the frame alignment counter counts.
- R9: If a write and a qualified strobe reach the same counter in the same cycle, the written value is loaded, the strobe is dropped and no interrupt or status results from it.
- R10: A synchronous active-low reset clears all three counters, the control register, the status register and `irq_pulse`.
- R11: The control register reads back its three bits with the upper bits as zero. Addresses 3, 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bpv_stb | input | 1 | One-cycle bipolar violation strobe |
| bpv_in_subst | input | 1 | Marks the violation as part of a recognised substitution word |
| crc_err_stb | input | 1 | One-cycle CRC-4 code word error strobe |
| fas_err_stb | input | 1 | One-cycle frame alignment word error strobe |
| resync_active | input | 1 | High while the receiver is re-acquiring alignment |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq_pulse | output | 1 | One-cycle interrupt pulse on an error at saturation |

## Verification
A wrong counter value shows on `reg_rdata` in the cycle after the faulty edge, but only while that counter is addressed. A counter that wrapped or skipped a count stays visible until the next write to it. A broken saturation compare shows up within one cycle on `irq_pulse`, which is checked on every cycle against a behavioural model. The status bits show the same fault more slowly, whenever address 5 is read. Faulty qualification gating is caught as a count that differs from the model, including strobes sent during resync, with CRC disabled, or flagged as substitution words. Random register writes and strobes, biased toward values near 0xFF, exercise write-versus-strobe collisions and saturation in many cycles.

// File: rtl/line_err_pkg.sv
// Package: shared constants and the control register layout for the
// line error counter bank. Assumes three counters in a fixed index order.
package line_err_pkg;
    localparam int NUM_CNT   = 3;
    localparam int IDX_BPV   = 0;
    localparam int IDX_CRC   = 1;
    localparam int IDX_FAS   = 2;
    localparam int CTRL_W    = 3;
    localparam int ADDR_CTRL = 4;
    localparam int ADDR_STAT = 5;

    // Control register fields, bit 0 at the bottom.
    typedef struct packed {
        logic irq_en;      // bit 2
        logic subst_excl;  // bit 1
        logic crc_en;      // bit 0
    } ctrl_t;
endpackage

// File: rtl/err_qualify.sv
// err_qualify: applies the counting rules to raw error strobes.
// Assumes strobes are single-cycle and the control bits are registered.
module err_qualify
    import line_err_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bpv_stb,
    input  logic               bpv_in_subst,
    input  logic               crc_err_stb,
    input  logic               fas_err_stb,
    input  logic               resync_active,
    input  ctrl_t              ctrl,
    output logic [NUM_CNT-1:0] inc_o
);

    // Per-counter gating: violations ignore resync, the others do not.
    always_comb begin
        inc_o          = '0;
        inc_o[IDX_BPV] = bpv_stb && !(ctrl.subst_excl && bpv_in_subst);
        inc_o[IDX_CRC] = crc_err_stb && ctrl.crc_en && !resync_active;
        inc_o[IDX_FAS] = fas_err_stb && !resync_active;
    end

    AST_CRC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.crc_en |-> !inc_o[IDX_CRC]);                          // R6
    AST_SUBST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.subst_excl && bpv_in_subst) |-> !inc_o[IDX_BPV]);     // R7
    AST_RESYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        resync_active |-> !(inc_o[IDX_CRC] || inc_o[IDX_FAS]));     // R8
endmodule

// File: rtl/sat_counter.sv
// sat_counter: one saturating up-counter with a software load port.
// A load wins over an increment in the same cycle. sat_evt_o flags an
// increment request that arrives while the count is at full scale.
module sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_o,
    output logic         sat_evt_o
);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic         at_full;

    assign at_full   = (cnt_q == FULL);
    // Saturation event: a counted error that has no room left.
    assign sat_evt_o = inc && !wr_en && at_full;
    assign cnt_o     = cnt_q;

    // Count register: reset, load, or step toward full scale.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wr_en)
            cnt_q <= wr_data;
        else if (inc && !at_full)
            cnt_q <= cnt_q + 1'b1;
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_en && cnt_q != FULL) |=> cnt_q == $past(cnt_q) + 1'b1); // R1
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == FULL && !wr_en) |=> cnt_q == FULL);                        // R2
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cnt_q == $past(wr_data));                                  // R9
endmodule

// File: rtl/err_irq.sv
// err_irq: turns saturation events into a registered one-cycle interrupt
// and per-counter sticky status bits, cleared by writing ones.
// Assumes sat_evt is already suppressed when a load hits the counter.
module err_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sat_evt,
    input  logic         irq_en,
    input  logic         clr_en,
    input  logic [N-1:0] clr_mask,
    output logic         irq_o,
    output logic [N-1:0] status_o
);
    logic [N-1:0] status_q;
    logic         irq_q;
    logic [N-1:0] clr_bits;

    assign clr_bits = clr_en ? clr_mask : '0;

    // Interrupt pulse: one cycle per cycle holding any saturated error.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (|sat_evt) && irq_en;
    end

    // Sticky status: new events win over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_bits) | sat_evt;
    end

    assign irq_o    = irq_q;
    assign status_o = status_q;

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|sat_evt) && $past(irq_en));                // R3
    AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|sat_evt) |=> ((status_o & $past(sat_evt)) == $past(sat_evt))); // R4
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq_o);                                        // R3
endmodule

// File: rtl/line_err_counters.sv
// line_err_counters: top of the error counter bank. Holds the control
// register, decodes the register port, instantiates one saturating counter
// per error class, and feeds saturation events to the interrupt logic.
// Assumes a single-master register port with combinational read data.
module line_err_counters
    import line_err_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bpv_stb,
    input  logic              bpv_in_subst,
    input  logic              crc_err_stb,
    input  logic              fas_err_stb,
    input  logic              resync_active,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq_pulse
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

    ctrl_t              ctrl_q;
    logic [NUM_CNT-1:0] inc;
    logic [NUM_CNT-1:0] cnt_wr;
    logic [NUM_CNT-1:0] sat_evt;
    logic [NUM_CNT-1:0] status;
    logic [CNT_W-1:0]   cnt_a [NUM_CNT];
    logic               ctrl_wr;
    logic               stat_wr;

    assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
    assign stat_wr = reg_wr && (reg_addr == A_STAT);

    // Control register: software-set counting and interrupt options.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    err_qualify u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .bpv_stb      (bpv_stb),
        .bpv_in_subst (bpv_in_subst),
        .crc_err_stb  (crc_err_stb),
        .fas_err_stb  (fas_err_stb),
        .resync_active(resync_active),
        .ctrl         (ctrl_q),
        .inc_o        (inc)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        assign cnt_wr[g] = reg_wr && (reg_addr == ADDR_W'(g));
        sat_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (inc[g]),
            .wr_en    (cnt_wr[g]),
            .wr_data  (reg_wdata),
            .cnt_o    (cnt_a[g]),
            .sat_evt_o(sat_evt[g])
        );
    end

    err_irq #(.N(NUM_CNT)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .sat_evt (sat_evt),
        .irq_en  (ctrl_q.irq_en),
        .clr_en  (stat_wr),
        .clr_mask(reg_wdata[NUM_CNT-1:0]),
        .irq_o   (irq_pulse),
        .status_o(status)
    );

    // Read mux: counters, control, status; all else reads zero.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CNT; i++)
            if (reg_addr == ADDR_W'(i)) reg_rdata = cnt_a[i];
        if (reg_addr == A_CTRL) reg_rdata[CTRL_W-1:0]  = ctrl_q;
        if (reg_addr == A_STAT) reg_rdata[NUM_CNT-1:0] = status;
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !irq_pulse && ctrl_q == '0 && status == '0);     // R10
    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ctrl_q == $past(reg_wdata[CTRL_W-1:0]));        // R11
endmodule

// File: tb/line_err_counters_tb.sv
// Bench: behavioural reference model, compared on every clock.
module line_err_counters_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       bpv_stb = 0, bpv_in_subst = 0, crc_err_stb = 0, fas_err_stb = 0;
    logic       resync_active = 0, reg_wr = 0;
    logic [2:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       irq_pulse;

    int n_tests = 0, n_fail = 0;
    int mcnt[3];
    int mctrl = 0, mstat = 0;
    bit mirq = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_err_counters u_dut (
        .clk(clk), .rst_n(rst_n), .bpv_stb(bpv_stb), .bpv_in_subst(bpv_in_subst),
        .crc_err_stb(crc_err_stb), .fas_err_stb(fas_err_stb),
        .resync_active(resync_active), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pulse(irq_pulse)
    );

    function automatic int mread(int a);
        if (a < 3)  return mcnt[a];
        if (a == 4) return mctrl;
        if (a == 5) return mstat;
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update for one clock edge, from the inputs held across it.
    task automatic model_edge();
        int sat = 0;
        bit q[3];
        if (!rst_n) begin
            foreach (mcnt[i]) mcnt[i] = 0;
            mctrl = 0; mstat = 0; mirq = 0;
            return;
        end
        q[0] = bpv_stb && !(bpv_in_subst && mctrl[1]);
        q[1] = crc_err_stb && mctrl[0] && !resync_active;
        q[2] = fas_err_stb && !resync_active;
        for (int i = 0; i < 3; i++) begin
            if (reg_wr && reg_addr == i) mcnt[i] = reg_wdata;
            else if (q[i]) begin
                if (mcnt[i] == 255) sat |= (1 << i);
                else mcnt[i]++;
            end
        end
        mirq = (sat != 0) && mctrl[2];
        if (reg_wr && reg_addr == 5) mstat = mstat & ~(reg_wdata & 7);
        mstat |= sat;
        if (reg_wr && reg_addr == 4) mctrl = reg_wdata & 7;
    endtask

    task automatic compare();
        string tag;
        check("R3 irq_pulse", irq_pulse, mirq);
        if (reg_addr < 3)       tag = "R1 counter read";
        else if (reg_addr == 5) tag = "R4 status read";
        else                    tag = "R11 ctrl/unused read";
        check(tag, reg_rdata, mread(reg_addr));
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic clear_in();
        bpv_stb = 0; bpv_in_subst = 0; crc_err_stb = 0; fas_err_stb = 0;
        reg_wr = 0;
    endtask

    task automatic wr(int a, int d);
        reg_wr = 1; reg_addr = 3'(a); reg_wdata = 8'(d);
        tick();
        reg_wr = 0;
    endtask

    task automatic rd_chk(string tag, int a, int exp);
        reg_addr = 3'(a);
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic strobes(bit b, bit s, bit c, bit f, int n);
        bpv_stb = b; bpv_in_subst = s; crc_err_stb = c; fas_err_stb = f;
        repeat (n) tick();
        clear_in();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1;
        // R10: everything reads zero after reset
        for (int a = 0; a < 8; a++) rd_chk("R10 reset value", a, 0);
        check("R10 irq after reset", irq_pulse, 0);

        // R1: basic counting on each counter
        wr(4, 1);                              // crc_en only
        strobes(1, 0, 0, 0, 3);
        rd_chk("R1 bpv count", 0, 3);
        strobes(0, 0, 1, 1, 2);
        rd_chk("R1 crc count", 1, 2);
        rd_chk("R1 fas count", 2, 2);

        // R6: crc disabled
        wr(4, 0);
        strobes(0, 0, 1, 0, 4);
        rd_chk("R6 crc gated", 1, 2);

        // R8: resync blocks crc and fas; R7: bpv still counts
        wr(4, 1);
        resync_active = 1;
        strobes(1, 0, 1, 1, 3);
        resync_active = 0;
        rd_chk("R8 crc frozen", 1, 2);
        rd_chk("R8 fas frozen", 2, 2);
        rd_chk("R7 bpv during resync", 0, 6);

        // R7: substitution exclusion
        wr(4, 2);
        strobes(1, 1, 0, 0, 3);
        rd_chk("R7 subst excluded", 0, 6);
        wr(4, 0);
        strobes(1, 1, 0, 0, 2);
        rd_chk("R7 subst counted", 0, 8);

        // R5/R2/R3/R4: preset near full and run into saturation
        wr(4, 7);
        wr(2, 8'hFD);
        fas_err_stb = 1;
        tick(); tick();
        rd_chk("R5 preset climbs", 2, 8'hFF);
        tick();
        check("R3 irq on saturated error", irq_pulse, 1);
        tick();
        fas_err_stb = 0;
        rd_chk("R2 no wrap", 2, 8'hFF);
        rd_chk("R4 status set", 5, 4);
        wr(5, 4);
        rd_chk("R4 status cleared", 5, 0);
        wr(2, 8'h10);
        strobes(0, 0, 0, 1, 1);
        check("R5 no irq after rewrite", irq_pulse, 0);
        rd_chk("R5 count after rewrite", 2, 8'h11);

        // R3 mask off: status still sets
        wr(4, 1);
        wr(1, 8'hFF);
        strobes(0, 0, 1, 0, 1);
        check("R3 masked irq", irq_pulse, 0);
        rd_chk("R4 status with mask off", 5, 2);

        // R4: set wins over same-cycle clear
        crc_err_stb = 1;
        wr(5, 2);
        clear_in();
        rd_chk("R4 set beats clear", 5, 2);

        // R9: write collides with strobe at saturation
        wr(4, 4);
        wr(0, 8'hFF);
        bpv_stb = 1;
        wr(0, 5);
        clear_in();
        check("R9 no irq on collision", irq_pulse, 0);
        rd_chk("R9 write wins", 0, 5);

        // R11: control readback and unused addresses
        wr(4, 8'hFF);
        rd_chk("R11 ctrl readback", 4, 7);
        rd_chk("R11 unused 3", 3, 0);
        rd_chk("R11 unused 7", 7, 0);

        // Random phase, biased toward saturation
        for (int k = 0; k < 4000; k++) begin
            bpv_stb       = ($urandom % 3) == 0;
            bpv_in_subst  = $urandom % 2;
            crc_err_stb   = ($urandom % 3) == 0;
            fas_err_stb   = ($urandom % 3) == 0;
            resync_active = ($urandom % 5) == 0;
            reg_wr        = ($urandom % 12) == 0;
            reg_addr      = 3'($urandom % 8);
            reg_wdata     = ($urandom % 2) ? 8'(8'hFF - ($urandom % 4)) : 8'($urandom);
            tick();
        end
        clear_in();
        resync_active = 0;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule